// File: doc/BRIEF.md
# Power Mode Supervisor State Machine

This block decides the operating mode of a supply-and-bus supervisor chip. It keeps one of six states (Init, Normal, Stop, Sleep, Restart, Fail-Safe). From that state it drives the reset output, the main-regulator enable, the enable for the secondary regulator and bus transceiver, a one-cycle wake interrupt and a sticky flag for rejected serial commands.

Its inputs are already decoded:
- a strobe carrying a three-bit command from the serial-port front end;
- wake strobes, plus two wake qualifiers: whether any wake source is enabled, and whether any wake-status flag is still pending;
- strobes for a watchdog failure, a main-supply undervoltage, an overtemperature shutdown and an overtemperature release;
- a per-failure policy input that sends a watchdog failure to Fail-Safe instead of Restart;
- a development strap that masks watchdog failures;
- a time-base tick.

The reset delay and the minimum Fail-Safe dwell are counted in ticks.

Commands that would leave the system with no way to wake, or that skip a required step, are refused. The flag is raised and the machine passes through Restart, so the host comes back in a defined state.

Top module: `pwr_mode_fsm`

## Requirements
- R1: After a synchronous reset the mode output reads 0 (Init), reset output high, main regulator enabled, peripherals disabled, flag low. Mode codes are Init=0, Normal=1, Stop=2, Sleep=3, Restart=4, Fail-Safe=5.
- R2: In Init any command strobe, whatever its code (including 7), moves the machine to Normal on the next clock. A wake strobe in Init changes nothing and raises no interrupt.
- R3: A watchdog-failure strobe in Init, Normal or Stop enters Restart, or Fail-Safe when the policy input is high. The strobe has no effect while the development strap is high.
- R4: In Normal the command codes act as follows:
  - 1 enters Stop;
  - 2 enters Sleep when a wake source is enabled and no wake flag is pending;
  - 3 (soft reset) returns to Init;
  - 4 (watchdog refresh) clears the undervoltage tally;
  - 5 (status read/clear) clears the flag;
  - 7 sets the flag and the mode is kept;
  - 0 and 6 change nothing.
- R5: Command 2 received in Stop sets the flag and enters Restart.
- R6: Command 2 in Normal while no wake source is enabled sets the flag and enters Restart.
- R7: Command 2 in Normal while a wake flag is pending enters Restart without setting the flag, and the machine then returns to Normal.
- R8: In Stop:
  - codes 1, 6 and 7 set the flag and keep Stop;
  - code 0 enters Normal;
  - code 3 enters Init;
  - code 4 and code 5 are accepted without a mode change.
- R9: Restart drives the reset output low and keeps the main regulator on. With a tick on every cycle, Restart lasts RST_DLY_TICKS+1 cycles and then enters Normal. Only Normal or Fail-Safe may follow Restart.
- R10: Fail-Safe turns off both enables and holds reset low. After a non-thermal entry it lasts at least FS_SHORT_TICKS ticks. A wake or release strobe arriving during the dwell is stored and causes Restart once the dwell has run out. With no wake, the machine stays in Fail-Safe.
- R11: Each undervoltage strobe in Init, Normal, Stop or Restart enters Restart. The UV_LIMIT-th strobe since the last clear enters Fail-Safe instead. A watchdog refresh or a Fail-Safe entry clears the tally.
- R12: A wake strobe in Normal or Stop pulses the interrupt for one cycle on the next clock, with no mode change. A wake strobe in Sleep enters Restart.
- R13: The flag stays set until a code-5 command is accepted in Normal or Stop.
- R14: An overtemperature strobe enters Fail-Safe from any state with a dwell of FS_LONG_TICKS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Time-base tick for delay and dwell counting |
| cmd_valid_i | input | 1 | Decoded serial command strobe |
| cmd_i | input | 3 | Command code (0 Normal, 1 Stop, 2 Sleep, 3 soft reset, 4 refresh, 5 status, 6 config write, 7 illegal) |
| wake_evt_i | input | 1 | Wake event strobe |
| wake_src_en_i | input | 1 | At least one wake source enabled |
| wake_pend_i | input | 1 | At least one wake-status flag still set |
| wd_fail_i | input | 1 | Watchdog failure strobe |
| wd_fs_req_i | input | 1 | Policy: watchdog failure goes to Fail-Safe |
| uv_evt_i | input | 1 | Main-supply undervoltage strobe |
| tsd_evt_i | input | 1 | Overtemperature shutdown strobe |
| ot_release_i | input | 1 | Overtemperature release strobe |
| dev_strap_i | input | 1 | Development strap, masks watchdog failures |
| mode_o | output | 3 | Current mode code |
| rst_out_n_o | output | 1 | Reset output, active low |
| vcc1_en_o | output | 1 | Main regulator enable |
| periph_en_o | output | 1 | Secondary regulator and transceiver enable |
| wake_irq_o | output | 1 | One-cycle wake interrupt |
| spi_fail_o | output | 1 | Sticky rejected-command flag |

## Verification
The bench aims at the edges of each timed stay. It counts the exact number of cycles spent in Restart and in both kinds of Fail-Safe dwell, so an off-by-one reload or a dwell shortened on thermal entry shows up as a wrong count. A wake strobe is placed inside the dwell to catch a design that drops it or leaves too early; an idle dwell catches one that leaves with no wake at all.

Undervoltage strobes are sent before and after a refresh so that a tally that does not clear, or that trips one event early, lands in the wrong mode. The refused Sleep and Stop requests check that the flag is set exactly when required: a design that forgets it, or sets it on a pending-wake Sleep, is caught.

// File: rtl/pwr_mode_pkg.sv
// Shared codes for the power mode supervisor.
// Assumes: mode and command codes are fixed at three bits each.
package pwr_mode_pkg;

    localparam int MODE_W = 3;
    localparam int CMD_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_INIT     = 3'd0,
        MODE_NORMAL   = 3'd1,
        MODE_STOP     = 3'd2,
        MODE_SLEEP    = 3'd3,
        MODE_RESTART  = 3'd4,
        MODE_FAILSAFE = 3'd5
    } mode_e;

    typedef enum logic [CMD_W-1:0] {
        CMD_NORMAL  = 3'd0,
        CMD_STOP    = 3'd1,
        CMD_SLEEP   = 3'd2,
        CMD_SOFTRST = 3'd3,
        CMD_WDREF   = 3'd4,
        CMD_STATUS  = 3'd5,
        CMD_CFG     = 3'd6,
        CMD_BAD     = 3'd7
    } cmd_e;

    // Outcome of judging one command against the current mode.
    typedef struct packed {
        mode_e target;
        logic  fail_set;
        logic  fail_clr;
        logic  uv_clr;
    } verdict_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pwr_cmd_judge.sv
// Judges a decoded serial command against the current mode.
// Purely combinational: it gives the mode the command asks for and its flag and tally side effects.
// Assumes: faults of higher priority are resolved by the caller, which
// drops this verdict when such a fault is present.
module pwr_cmd_judge
    import pwr_mode_pkg::*;
(
    input  mode_e    mode_i,
    input  logic     cmd_valid_i,
    input  cmd_e     cmd_i,
    input  logic     wake_src_en_i,
    input  logic     wake_pend_i,
    output verdict_t verdict_o
);

    // Decide the target mode and side effects for this command.
    always_comb begin
        verdict_o          = '0;
        verdict_o.target   = mode_i;
        if (cmd_valid_i) begin
            unique case (mode_i)
                MODE_INIT: verdict_o.target = MODE_NORMAL;
                MODE_NORMAL: begin
                    unique case (cmd_i)
                        CMD_STOP:    verdict_o.target = MODE_STOP;
                        CMD_SLEEP: begin
                            if (!wake_src_en_i) begin
                                verdict_o.target   = MODE_RESTART;
                                verdict_o.fail_set = 1'b1;
                            end else if (wake_pend_i) begin
                                verdict_o.target   = MODE_RESTART;
                            end else begin
                                verdict_o.target   = MODE_SLEEP;
                            end
                        end
                        CMD_SOFTRST: verdict_o.target   = MODE_INIT;
                        CMD_WDREF:   verdict_o.uv_clr   = 1'b1;
                        CMD_STATUS:  verdict_o.fail_clr = 1'b1;
                        CMD_BAD:     verdict_o.fail_set = 1'b1;
                        default:     verdict_o.target   = mode_i;
                    endcase
                end
                MODE_STOP: begin
                    unique case (cmd_i)
                        CMD_NORMAL:  verdict_o.target   = MODE_NORMAL;
                        CMD_SOFTRST: verdict_o.target   = MODE_INIT;
                        CMD_WDREF:   verdict_o.uv_clr   = 1'b1;
                        CMD_STATUS:  verdict_o.fail_clr = 1'b1;
                        CMD_SLEEP: begin
                            verdict_o.target   = MODE_RESTART;
                            verdict_o.fail_set = 1'b1;
                        end
                        default:     verdict_o.fail_set = 1'b1;
                    endcase
                end
                default: verdict_o.target = mode_i;
            endcase
        end
    end

endmodule

// File: rtl/pwr_dwell_timer.sv
// Down-counter for the reset delay and the Fail-Safe dwell.
// A load sets the count; each tick then takes one off until it reaches zero.
// Assumes: a load has priority over a tick in the same cycle.
module pwr_dwell_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load, or count down on a tick while above zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pwr_uv_tally.sv
// Counts undervoltage events since the last clear.
// It flags, in the same cycle, the event that reaches the limit.
// Assumes: the caller clears the tally when it acts on the flagged event.
module pwr_uv_tally #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    output logic hit_o
);

    localparam int              W    = $clog2(LIMIT + 1);
    localparam logic [W-1:0]    LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    assign hit_o = evt_i && (cnt_q == LAST);

    // Clear on request, else count each event up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (evt_i && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwr_mode_fsm.sv
// Operating-mode controller of the supply-and-bus supervisor.
// Resolves, in each cycle and in priority order: thermal shutdown, undervoltage, watchdog failure, commands, timers and wakes.
// Assumes: every strobe input is high for one cycle per event, tick_i comes at
// most once per clock, and all inputs are synchronous to clk.
module pwr_mode_fsm #(
    parameter int RST_DLY_TICKS  = 8,
    parameter int FS_SHORT_TICKS = 20,
    parameter int FS_LONG_TICKS  = 200,
    parameter int UV_LIMIT       = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       cmd_valid_i,
    input  logic [2:0] cmd_i,
    input  logic       wake_evt_i,
    input  logic       wake_src_en_i,
    input  logic       wake_pend_i,
    input  logic       wd_fail_i,
    input  logic       wd_fs_req_i,
    input  logic       uv_evt_i,
    input  logic       tsd_evt_i,
    input  logic       ot_release_i,
    input  logic       dev_strap_i,
    output logic [2:0] mode_o,
    output logic       rst_out_n_o,
    output logic       vcc1_en_o,
    output logic       periph_en_o,
    output logic       wake_irq_o,
    output logic       spi_fail_o
);
    import pwr_mode_pkg::*;

    localparam int TMR_MAX = max3(RST_DLY_TICKS, FS_SHORT_TICKS, FS_LONG_TICKS);
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0] LD_RST   = TMR_W'(RST_DLY_TICKS);
    localparam logic [TMR_W-1:0] LD_SHORT = TMR_W'(FS_SHORT_TICKS);
    localparam logic [TMR_W-1:0] LD_LONG  = TMR_W'(FS_LONG_TICKS);

    mode_e             mode_q, mode_nxt;
    logic              fs_pend_q, fs_pend_nxt;
    logic              irq_q, fail_q;
    logic              live, uv_qual, wd_qual, wake_any, uv_hit, uv_clr;
    logic              tmr_load, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;
    logic              fail_set, fail_clr;
    verdict_t          verdict;

    assign live     = (mode_q == MODE_INIT) || (mode_q == MODE_NORMAL) || (mode_q == MODE_STOP);
    assign uv_qual  = uv_evt_i && !tsd_evt_i && (live || (mode_q == MODE_RESTART));
    assign wd_qual  = wd_fail_i && !dev_strap_i && live;
    assign wake_any = wake_evt_i || ot_release_i;

    pwr_cmd_judge u_judge (
        .mode_i        (mode_q),
        .cmd_valid_i   (cmd_valid_i),
        .cmd_i         (cmd_e'(cmd_i)),
        .wake_src_en_i (wake_src_en_i),
        .wake_pend_i   (wake_pend_i),
        .verdict_o     (verdict)
    );

    pwr_dwell_timer #(.CNT_W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .tick_i     (tick_i),
        .zero_o     (tmr_zero)
    );

    pwr_uv_tally #(.LIMIT(UV_LIMIT)) u_uv (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (uv_qual),
        .clr_i (uv_clr),
        .hit_o (uv_hit)
    );

    // Choose the next mode and the timer load, in priority order.
    always_comb begin
        mode_nxt = mode_q;
        tmr_load = 1'b0;
        tmr_val  = LD_RST;
        fail_set = 1'b0;
        fail_clr = 1'b0;
        uv_clr   = 1'b0;
        if (tsd_evt_i) begin
            mode_nxt = MODE_FAILSAFE;
            tmr_load = 1'b1;
            tmr_val  = LD_LONG;
        end else if (uv_qual) begin
            tmr_load = 1'b1;
            if (uv_hit) begin
                mode_nxt = MODE_FAILSAFE;
                tmr_val  = LD_SHORT;
            end else begin
                mode_nxt = MODE_RESTART;
            end
        end else if (wd_qual) begin
            tmr_load = 1'b1;
            if (wd_fs_req_i) begin
                mode_nxt = MODE_FAILSAFE;
                tmr_val  = LD_SHORT;
            end else begin
                mode_nxt = MODE_RESTART;
            end
        end else begin
            unique case (mode_q)
                MODE_INIT, MODE_NORMAL, MODE_STOP: begin
                    mode_nxt = verdict.target;
                    fail_set = verdict.fail_set;
                    fail_clr = verdict.fail_clr;
                    uv_clr   = verdict.uv_clr;
                    tmr_load = (verdict.target == MODE_RESTART);
                end
                MODE_RESTART: begin
                    if (tmr_zero) mode_nxt = MODE_NORMAL;
                end
                MODE_SLEEP: begin
                    if (wake_evt_i) begin
                        mode_nxt = MODE_RESTART;
                        tmr_load = 1'b1;
                    end
                end
                MODE_FAILSAFE: begin
                    if (tmr_zero && (fs_pend_q || wake_any)) begin
                        mode_nxt = MODE_RESTART;
                        tmr_load = 1'b1;
                    end
                end
                default: mode_nxt = MODE_INIT;
            endcase
        end
        if (mode_nxt == MODE_FAILSAFE) uv_clr = 1'b1;
    end

    // Wakes are stored only while the machine stays in Fail-Safe.
    always_comb begin
        if ((mode_q == MODE_FAILSAFE) && (mode_nxt == MODE_FAILSAFE)) begin
            fs_pend_nxt = fs_pend_q || wake_any;
        end else begin
            fs_pend_nxt = 1'b0;
        end
    end

    // State, stored wake, interrupt pulse and sticky flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_INIT;
            fs_pend_q <= 1'b0;
            irq_q     <= 1'b0;
            fail_q    <= 1'b0;
        end else begin
            mode_q    <= mode_nxt;
            fs_pend_q <= fs_pend_nxt;
            irq_q     <= wake_evt_i && ((mode_q == MODE_NORMAL) || (mode_q == MODE_STOP));
            if (fail_set) begin
                fail_q <= 1'b1;
            end else if (fail_clr) begin
                fail_q <= 1'b0;
            end
        end
    end

    assign mode_o      = mode_q;
    assign rst_out_n_o = !((mode_q == MODE_RESTART) || (mode_q == MODE_SLEEP) ||
                           (mode_q == MODE_FAILSAFE));
    assign vcc1_en_o   = live || (mode_q == MODE_RESTART);
    assign periph_en_o = (mode_q == MODE_NORMAL) || (mode_q == MODE_STOP);
    assign wake_irq_o  = irq_q;
    assign spi_fail_o  = fail_q;

endmodule

// File: rtl/pwr_mode_fsm_chk.sv
// Property checker for the power mode supervisor, attached by bind.
// It watches only the top-level ports; the dwell lower bound is checked with a cycle counter.
module pwr_mode_fsm_chk
    import pwr_mode_pkg::*;
#(
    parameter int FS_SHORT_TICKS = 20
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid_i,
    input logic [2:0] cmd_i,
    input logic       wake_evt_i,
    input logic       wake_src_en_i,
    input logic       wd_fail_i,
    input logic       uv_evt_i,
    input logic       tsd_evt_i,
    input logic       dev_strap_i,
    input logic [2:0] mode_o,
    input logic       rst_out_n_o,
    input logic       vcc1_en_o,
    input logic       wake_irq_o,
    input logic       spi_fail_o
);

    localparam int FC_W = $clog2(FS_SHORT_TICKS + 2);

    logic            quiet;
    logic [FC_W-1:0] fs_cyc;

    assign quiet = !tsd_evt_i && !uv_evt_i && !(wd_fail_i && !dev_strap_i);

    // Cycles spent in Fail-Safe since entry, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || (mode_o != MODE_FAILSAFE)) begin
            fs_cyc <= '0;
        end else if (fs_cyc != {FC_W{1'b1}}) begin
            fs_cyc <= fs_cyc + 1'b1;
        end
    end

    a_r2_init_any_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_INIT && cmd_valid_i && quiet) |=> (mode_o == MODE_NORMAL));

    a_r2_init_wake_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_INIT && wake_evt_i && !cmd_valid_i && quiet)
        |=> (mode_o == MODE_INIT && !wake_irq_o));

    a_r5_stop_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_STOP && cmd_valid_i && cmd_i == CMD_SLEEP && quiet)
        |=> (mode_o == MODE_RESTART && spi_fail_o));

    a_r6_no_wake_source: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_NORMAL && cmd_valid_i && cmd_i == CMD_SLEEP && !wake_src_en_i && quiet)
        |=> (mode_o == MODE_RESTART && spi_fail_o));

    a_r9_restart_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_RESTART)
        |=> (mode_o == MODE_RESTART || mode_o == MODE_NORMAL || mode_o == MODE_FAILSAFE));

    a_r9_restart_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_RESTART) |-> (!rst_out_n_o && vcc1_en_o));

    a_r10_min_dwell: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_FAILSAFE && int'(fs_cyc) < FS_SHORT_TICKS) |=> (mode_o == MODE_FAILSAFE));

    a_r12_sleep_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SLEEP && wake_evt_i && !tsd_evt_i) |=> (mode_o == MODE_RESTART));

    a_r13_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_fail_o) |-> $past(cmd_valid_i && cmd_i == CMD_STATUS &&
                                    (mode_o == MODE_NORMAL || mode_o == MODE_STOP)));

    a_r14_thermal: assert property (@(posedge clk) disable iff (!rst_n)
        tsd_evt_i |=> (mode_o == MODE_FAILSAFE && !vcc1_en_o));

endmodule

bind pwr_mode_fsm pwr_mode_fsm_chk #(.FS_SHORT_TICKS(FS_SHORT_TICKS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid_i   (cmd_valid_i),
    .cmd_i         (cmd_i),
    .wake_evt_i    (wake_evt_i),
    .wake_src_en_i (wake_src_en_i),
    .wd_fail_i     (wd_fail_i),
    .uv_evt_i      (uv_evt_i),
    .tsd_evt_i     (tsd_evt_i),
    .dev_strap_i   (dev_strap_i),
    .mode_o        (mode_o),
    .rst_out_n_o   (rst_out_n_o),
    .vcc1_en_o     (vcc1_en_o),
    .wake_irq_o    (wake_irq_o),
    .spi_fail_o    (spi_fail_o)
);

// File: tb/pwr_mode_fsm_tb.sv
`timescale 1ns/1ps
// Directed bench with a behavioural reference model that is compared on every clock.
module pwr_mode_fsm_tb;

    localparam int RST_T   = 5;
    localparam int SHORT_T = 12;
    localparam int LONG_T  = 40;
    localparam int UVL     = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b1;
    logic       cmd_valid_i = 1'b0;
    logic [2:0] cmd_i = 3'd0;
    logic       wake_evt_i = 1'b0, wake_src_en_i = 1'b1, wake_pend_i = 1'b0;
    logic       wd_fail_i = 1'b0, wd_fs_req_i = 1'b0, uv_evt_i = 1'b0;
    logic       tsd_evt_i = 1'b0, ot_release_i = 1'b0, dev_strap_i = 1'b0;
    logic [2:0] mode_o;
    logic       rst_out_n_o, vcc1_en_o, periph_en_o, wake_irq_o, spi_fail_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";
    bit    done = 0;

    always #2.5 clk = ~clk;

    pwr_mode_fsm #(
        .RST_DLY_TICKS(RST_T), .FS_SHORT_TICKS(SHORT_T),
        .FS_LONG_TICKS(LONG_T), .UV_LIMIT(UVL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
        .wake_evt_i(wake_evt_i), .wake_src_en_i(wake_src_en_i), .wake_pend_i(wake_pend_i),
        .wd_fail_i(wd_fail_i), .wd_fs_req_i(wd_fs_req_i), .uv_evt_i(uv_evt_i),
        .tsd_evt_i(tsd_evt_i), .ot_release_i(ot_release_i), .dev_strap_i(dev_strap_i),
        .mode_o(mode_o), .rst_out_n_o(rst_out_n_o), .vcc1_en_o(vcc1_en_o),
        .periph_en_o(periph_en_o), .wake_irq_o(wake_irq_o), .spi_fail_o(spi_fail_o)
    );

    // ---------------- reference model ----------------
    int m_mode, m_tmr, m_uv, m_pend, m_irq, m_fail;
    int nm, lv, was;
    bit m_ok = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_tmr = 0; m_uv = 0; m_pend = 0; m_irq = 0; m_fail = 0; m_ok = 1;
        end else begin
            was = m_mode;
            nm  = m_mode;
            lv  = -1;
            m_irq = (wake_evt_i && (m_mode == 1 || m_mode == 2)) ? 1 : 0;
            if (tsd_evt_i) begin
                nm = 5; lv = LONG_T;
            end else if (uv_evt_i && m_mode <= 2 || uv_evt_i && m_mode == 4) begin
                m_uv = m_uv + 1;
                if (m_uv >= UVL) begin nm = 5; lv = SHORT_T; end
                else begin nm = 4; lv = RST_T; end
            end else if (wd_fail_i && !dev_strap_i && m_mode <= 2) begin
                nm = wd_fs_req_i ? 5 : 4;
                lv = wd_fs_req_i ? SHORT_T : RST_T;
            end else if (m_mode <= 2) begin
                if (cmd_valid_i) begin
                    if (m_mode == 0) nm = 1;
                    else if (m_mode == 1) begin
                        if (cmd_i == 1) nm = 2;
                        else if (cmd_i == 2) begin
                            if (!wake_src_en_i) begin nm = 4; lv = RST_T; m_fail = 1; end
                            else if (wake_pend_i) begin nm = 4; lv = RST_T; end
                            else nm = 3;
                        end
                        else if (cmd_i == 3) nm = 0;
                        else if (cmd_i == 4) m_uv = 0;
                        else if (cmd_i == 5) m_fail = 0;
                        else if (cmd_i == 7) m_fail = 1;
                    end else begin
                        if (cmd_i == 0) nm = 1;
                        else if (cmd_i == 3) nm = 0;
                        else if (cmd_i == 4) m_uv = 0;
                        else if (cmd_i == 5) m_fail = 0;
                        else if (cmd_i == 2) begin nm = 4; lv = RST_T; m_fail = 1; end
                        else m_fail = 1;
                    end
                end
            end else if (m_mode == 4) begin
                if (m_tmr == 0) nm = 1;
            end else if (m_mode == 3) begin
                if (wake_evt_i) begin nm = 4; lv = RST_T; end
            end else if (m_mode == 5) begin
                if (m_tmr == 0 && (m_pend != 0 || wake_evt_i || ot_release_i)) begin
                    nm = 4; lv = RST_T;
                end
            end
            if (nm == 5) m_uv = 0;
            m_pend = (was == 5 && nm == 5) ? ((m_pend != 0 || wake_evt_i || ot_release_i) ? 1 : 0) : 0;
            if (lv >= 0) m_tmr = lv;
            else if (tick_i && m_tmr > 0) m_tmr = m_tmr - 1;
            m_mode = nm;
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (m_ok && !done) begin
            int e_rst, e_v1, e_pe;
            e_rst = (m_mode == 3 || m_mode == 4 || m_mode == 5) ? 0 : 1;
            e_v1  = (m_mode <= 2 || m_mode == 4) ? 1 : 0;
            e_pe  = (m_mode == 1 || m_mode == 2) ? 1 : 0;
            n_tests++;
            if (int'(mode_o) != m_mode || int'(rst_out_n_o) != e_rst || int'(vcc1_en_o) != e_v1 ||
                int'(periph_en_o) != e_pe || int'(wake_irq_o) != m_irq || int'(spi_fail_o) != m_fail) begin
                n_fail++;
                $display("FAIL %s model: actual mode=%0d rst=%0b v1=%0b pe=%0b irq=%0b fl=%0b expected mode=%0d rst=%0d v1=%0d pe=%0d irq=%0d fl=%0d",
                         cur_req, mode_o, rst_out_n_o, vcc1_en_o, periph_en_o, wake_irq_o, spi_fail_o,
                         m_mode, e_rst, e_v1, e_pe, m_irq, m_fail);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send(input int c);
        cmd_valid_i = 1'b1; cmd_i = 3'(c);
        @(negedge clk);
        cmd_valid_i = 1'b0;
    endtask

    // which: 0 wake, 1 watchdog, 2 undervoltage, 3 thermal, 4 release
    task automatic pulse(input int which);
        case (which)
            0: wake_evt_i = 1'b1;
            1: wd_fail_i = 1'b1;
            2: uv_evt_i = 1'b1;
            3: tsd_evt_i = 1'b1;
            default: ot_release_i = 1'b1;
        endcase
        @(negedge clk);
        wake_evt_i = 1'b0; wd_fail_i = 1'b0; uv_evt_i = 1'b0; tsd_evt_i = 1'b0; ot_release_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_leave(input int m, output int k);
        k = 0;
        while (int'(mode_o) == m && k < 1000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL %s watchdog: actual=running expected=finished", cur_req);
            finish_run();
        end
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "mode", mode_o, 0);
        chk("R1", "rst_out_n", rst_out_n_o, 1);
        chk("R1", "vcc1_en", vcc1_en_o, 1);
        chk("R1", "periph_en", periph_en_o, 0);
        chk("R1", "spi_fail", spi_fail_o, 0);

        cur_req = "R2";
        pulse(0);
        chk("R2", "init wake mode", mode_o, 0);
        chk("R2", "init wake irq", wake_irq_o, 0);
        send(7);
        chk("R2", "illegal frame leaves init", mode_o, 1);

        cur_req = "R12";
        pulse(0);
        chk("R12", "normal wake irq", wake_irq_o, 1);
        chk("R12", "normal wake mode", mode_o, 1);
        @(negedge clk);
        chk("R12", "irq one cycle", wake_irq_o, 0);

        cur_req = "R4";
        send(7);
        chk("R4", "illegal sets flag", spi_fail_o, 1);
        chk("R4", "illegal keeps normal", mode_o, 1);
        cur_req = "R13";
        idle(2);
        chk("R13", "flag sticky", spi_fail_o, 1);
        send(5);
        chk("R13", "status clears flag", spi_fail_o, 0);

        cur_req = "R4";
        send(1);
        chk("R4", "enter stop", mode_o, 2);
        cur_req = "R8";
        send(6);
        chk("R8", "stop write flagged", spi_fail_o, 1);
        chk("R8", "stop write ignored", mode_o, 2);
        send(4);
        chk("R8", "refresh in stop", mode_o, 2);
        send(5);
        chk("R8", "status in stop", spi_fail_o, 0);
        pulse(0);
        chk("R12", "stop wake irq", wake_irq_o, 1);
        chk("R12", "stop wake mode", mode_o, 2);

        cur_req = "R5";
        send(2);
        chk("R5", "stop to sleep restarts", mode_o, 4);
        chk("R5", "stop to sleep flag", spi_fail_o, 1);
        cur_req = "R9";
        chk("R9", "restart reset low", rst_out_n_o, 0);
        wait_leave(4, k);
        chk("R9", "restart length", k, RST_T + 1);
        chk("R9", "restart ends in normal", mode_o, 1);
        send(5);

        cur_req = "R6";
        wake_src_en_i = 1'b0;
        send(2);
        chk("R6", "no source restarts", mode_o, 4);
        chk("R6", "no source flag", spi_fail_o, 1);
        wait_leave(4, k);
        wake_src_en_i = 1'b1;
        send(5);

        cur_req = "R7";
        wake_pend_i = 1'b1;
        send(2);
        chk("R7", "pending wake restarts", mode_o, 4);
        chk("R7", "pending wake no flag", spi_fail_o, 0);
        wait_leave(4, k);
        chk("R7", "back to normal", mode_o, 1);
        wake_pend_i = 1'b0;

        cur_req = "R4";
        send(2);
        chk("R4", "legal sleep", mode_o, 3);
        chk("R4", "sleep vcc1 off", vcc1_en_o, 0);
        idle(3);
        chk("R4", "sleep holds", mode_o, 3);
        cur_req = "R12";
        pulse(0);
        chk("R12", "sleep wake restarts", mode_o, 4);
        wait_leave(4, k);

        cur_req = "R3";
        pulse(1);
        chk("R3", "wd fail restarts", mode_o, 4);
        wait_leave(4, k);
        dev_strap_i = 1'b1;
        pulse(1);
        chk("R3", "strap masks wd", mode_o, 1);
        dev_strap_i = 1'b0;
        wd_fs_req_i = 1'b1;
        pulse(1);
        wd_fs_req_i = 1'b0;
        chk("R3", "wd policy failsafe", mode_o, 5);
        cur_req = "R10";
        chk("R10", "failsafe vcc1 off", vcc1_en_o, 0);
        chk("R10", "failsafe periph off", periph_en_o, 0);
        idle(3);
        pulse(0);
        wait_leave(5, k);
        chk("R10", "stored wake dwell", 4 + k, SHORT_T + 1);
        chk("R10", "stored wake restarts", mode_o, 4);
        wait_leave(4, k);
        wd_fs_req_i = 1'b1;
        pulse(1);
        wd_fs_req_i = 1'b0;
        idle(SHORT_T + 4);
        chk("R10", "no wake stays", mode_o, 5);
        pulse(0);
        chk("R10", "late wake restarts", mode_o, 4);
        wait_leave(4, k);

        cur_req = "R11";
        pulse(2);
        chk("R11", "uv 1 restarts", mode_o, 4);
        wait_leave(4, k);
        pulse(2);
        chk("R11", "uv 2 restarts", mode_o, 4);
        wait_leave(4, k);
        send(4);
        for (int i = 0; i < UVL - 1; i++) begin
            pulse(2);
            chk("R11", "uv after refresh restarts", mode_o, 4);
            wait_leave(4, k);
        end
        pulse(2);
        chk("R11", "uv limit failsafe", mode_o, 5);
        idle(SHORT_T + 2);
        pulse(0);
        wait_leave(4, k);
        chk("R11", "recovered", mode_o, 1);

        cur_req = "R14";
        pulse(3);
        chk("R14", "thermal failsafe", mode_o, 5);
        pulse(4);
        idle(SHORT_T + 4);
        chk("R14", "long dwell holds", mode_o, 5);
        wait_leave(5, k);
        chk("R14", "long dwell length", 1 + SHORT_T + 4 + k, LONG_T + 1);
        wait_leave(4, k);

        cur_req = "R4";
        send(3);
        chk("R4", "soft reset to init", mode_o, 0);
        cur_req = "R3";
        pulse(1);
        chk("R3", "wd in init restarts", mode_o, 4);
        wait_leave(4, k);
        chk("R3", "init wd recovers", mode_o, 1);

        idle(2);
        finish_run();
    end

endmodule